// File: doc/BRIEF.md
# Tagged Entry Word Repacker

This block joins a 32-bit host register port to two small internal queues of 16-bit entries. On the transmit side, a host word carries up to two tagged entries (a tag code in the upper byte and a data or address byte in the lower byte). The entry in bits 15:0 is queued first and the entry in bits 31:16 follows one cycle later. A serial engine, outside this block, drains the transmit queue one entry at a time. When splitting is enabled, an all-zero upper half marks a message with an odd entry count and is dropped. When splitting is disabled, only the low half is ever queued.

On the receive side, the engine pushes 16-bit received entries, each holding its byte in bits 7:0. A host read sees a combinational view of the queue head. With merging enabled and two or more entries queued, the read returns the first entry at bits 15:0 and the second at bits 31:16, so the two received bytes land at bits 7:0 and 23:16, and both entries are removed. With only one entry queued, or with merging disabled, the read returns one entry in the low half and removes one.

The host polls the full flag before writing and the availability flag before reading. Misuse on either side is ignored and recorded in two sticky error flags.

The transmit side runs a two-state machine. TX_IDLE goes to TX_HOLD_HI when it accepts a write whose upper half is nonzero and splitting is on. TX_HOLD_HI goes back to TX_IDLE in the first cycle the queue has room for the held upper entry. In every other case TX_IDLE stays put. The receive side sorts each cycle into one of three availability classes: RX_NONE (empty), RX_ONE (one entry) and RX_TWO (two or more). That class selects the read word and the pop count.

Top module: `tagword_repacker`

## Requirements
- R1: After reset both queues are empty: host_out_full, eng_out_avail, host_in_avail, eng_in_full, err_overflow and err_underflow are 0, and host_rd_data is 0.
- R2: With out_split_en=1, a host write whose bits 31:16 are nonzero queues bits 15:0 at the clock edge that samples the write, and queues bits 31:16 at the following edge. The engine receives them in that order.
- R3: While the upper half of a write is still waiting to be queued, host_out_full reads 1. A host write accepted in that cycle is dropped and sets err_overflow.
- R4: With out_split_en=1, a host write whose bits 31:16 are zero queues only its bits 15:0.
- R5: With out_split_en=0, a host write queues only bits 15:0, and bits 31:16 are discarded even when nonzero.
- R6: With in_merge_en=1 and at least two entries queued, host_rd_data equals {second entry, first entry}: the first entry sits at bits 15:0 and the second at bits 31:16. A read removes both.
- R7: With exactly one entry queued, host_rd_data equals {16'h0000, entry}, and a read removes just that entry.
- R8: With in_merge_en=0, host_rd_data equals {16'h0000, first entry}, and a read removes one entry even when more are queued.
- R9: A host read while the receive queue is empty returns 0, changes no queue, and sets err_underflow. An engine pop while the transmit queue is empty is ignored and also sets err_underflow.
- R10: A host write while host_out_full is 1, or an engine push while eng_in_full is 1, is ignored and sets err_overflow. Both error flags stay at 1 until reset.
- R11: host_out_full is 1 when the transmit queue holds DEPTH entries. eng_in_full is 1 when the receive queue holds DEPTH entries. eng_out_avail and host_in_avail are 1 whenever their queue is not empty.
- R12: Both queues are first-in first-out, including across storage wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_split_en | input | 1 | Queue the upper half of host writes as a second entry |
| in_merge_en | input | 1 | Combine two received entries into one host read |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_data | input | 32 | Host write word, entry at 15:0 and entry at 31:16 |
| host_out_full | output | 1 | Transmit side cannot accept a write |
| host_rd_en | input | 1 | Host read strobe; pops the entries shown |
| host_rd_data | output | 32 | Host read word |
| host_in_avail | output | 1 | Receive queue holds at least one entry |
| eng_out_pop | input | 1 | Engine takes the head transmit entry |
| eng_out_entry | output | 16 | Head transmit entry |
| eng_out_avail | output | 1 | Transmit queue holds at least one entry |
| eng_in_push | input | 1 | Engine delivers a received entry |
| eng_in_entry | input | 16 | Received entry, byte in 7:0 |
| eng_in_full | output | 1 | Receive queue holds DEPTH entries |
| err_overflow | output | 1 | Sticky: a push met a full side |
| err_underflow | output | 1 | Sticky: a pop met an empty side |

## Verification
The bench goes after the second half of a split write. It writes again in the cycle the upper entry is still held: a design that ignored the hold state would queue the wrong entry or lose the held one, and the drain order would show it. It checks odd-entry handling in both directions. A zero upper half must not appear as a phantom zero entry. A read with a single received entry must not drag in a stale second slot or remove two entries, which would skew the next read. It fills both queues to DEPTH and keeps cycling them past the wrap point: an off-by-one full test, a push that is not dropped when full, or a pointer that wraps wrongly shows up as a missing, duplicated or reordered entry.

// File: rtl/repack_pkg.sv
package repack_pkg;

    // transmit splitter: idle, or holding the upper entry of a write
    typedef enum logic {
        TX_IDLE,
        TX_HOLD_HI
    } tx_state_e;

    // receive side: how many entries a read may take this cycle
    typedef enum logic [1:0] {
        RX_NONE,
        RX_ONE,
        RX_TWO
    } rx_avail_e;

endpackage

// File: rtl/repack_fifo.sv
module repack_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic [1:0]       pop_n,
    output logic [W-1:0]     head0,
    output logic [W-1:0]     head1,
    output logic [CNT_W-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          push_ok;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] p, input int unsigned n);
        int unsigned s;
        s = int'(p) + n;
        return AW'(s % DEPTH);
    endfunction

    // a push into a full queue is dropped
    assign push_ok = push && (count != CNT_W'(DEPTH));
    assign head0   = mem[rd_ptr];
    assign head1   = mem[advance(rd_ptr, 1)];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= advance(wr_ptr, 1);
            end
            rd_ptr <= advance(rd_ptr, pop_n);
            count  <= count + CNT_W'(push_ok) - CNT_W'(pop_n);
        end
    end

    assert_fifo_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_fifo_pop_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(pop_n) <= count);

    assert_fifo_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == CNT_W'(DEPTH) && pop_n == 2'd0) |=> $stable(count));

endmodule

// File: rtl/repack_tx_split.sv
module repack_tx_split
    import repack_pkg::*;
#(
    parameter int ENTRY_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2*ENTRY_W-1:0] wr_data,
    input  logic                 split_en,
    input  logic                 fifo_full,
    output logic                 push,
    output logic [ENTRY_W-1:0]   push_data,
    output logic                 busy,
    output logic                 ovf
);
    tx_state_e          state_q, state_d;
    logic [ENTRY_W-1:0] hi_q, hi_d;
    logic [ENTRY_W-1:0] wr_lo, wr_hi;

    assign wr_lo = wr_data[ENTRY_W-1:0];
    assign wr_hi = wr_data[2*ENTRY_W-1:ENTRY_W];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            hi_q    <= hi_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        hi_d      = hi_q;
        push      = 1'b0;
        push_data = wr_lo;
        ovf       = 1'b0;
        busy      = (state_q == TX_HOLD_HI);
        unique case (state_q)
            TX_IDLE: begin
                if (wr_en) begin
                    if (fifo_full) begin
                        ovf = 1'b1;
                    end else begin
                        push = 1'b1;
                        if (split_en && (wr_hi != '0)) begin
                            hi_d    = wr_hi;
                            state_d = TX_HOLD_HI;
                        end
                    end
                end
            end
            TX_HOLD_HI: begin
                ovf = wr_en;
                if (!fifo_full) begin
                    push      = 1'b1;
                    push_data = hi_q;
                    state_d   = TX_IDLE;
                end
            end
        endcase
    end

    assert_hold_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_HOLD_HI && !fifo_full) |=> (state_q == TX_IDLE));

    assert_zero_upper_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && wr_en && wr_hi == '0) |=> (state_q == TX_IDLE));

    assert_no_split_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && !split_en) |=> (state_q == TX_IDLE));

endmodule

// File: rtl/repack_rx_merge.sv
module repack_rx_merge
    import repack_pkg::*;
#(
    parameter int ENTRY_W = 16,
    parameter int CNT_W   = 4
) (
    input  logic                 rd_en,
    input  logic                 merge_en,
    input  logic [CNT_W-1:0]     count,
    input  logic [ENTRY_W-1:0]   head0,
    input  logic [ENTRY_W-1:0]   head1,
    output logic [2*ENTRY_W-1:0] rd_data,
    output logic [1:0]           pop_n,
    output logic                 udf
);
    rx_avail_e avail;

    always_comb begin
        if (count == '0) begin
            avail = RX_NONE;
        end else if (count == CNT_W'(1)) begin
            avail = RX_ONE;
        end else begin
            avail = RX_TWO;
        end
    end

    always_comb begin
        rd_data = '0;
        pop_n   = 2'd0;
        udf     = 1'b0;
        unique case (avail)
            RX_NONE: begin
                udf = rd_en;
            end
            RX_ONE: begin
                rd_data = {{ENTRY_W{1'b0}}, head0};
                pop_n   = rd_en ? 2'd1 : 2'd0;
            end
            RX_TWO: begin
                if (merge_en) begin
                    rd_data = {head1, head0};
                    pop_n   = rd_en ? 2'd2 : 2'd0;
                end else begin
                    rd_data = {{ENTRY_W{1'b0}}, head0};
                    pop_n   = rd_en ? 2'd1 : 2'd0;
                end
            end
        endcase
    end

    always_comb begin
        assert_rx_pop_bound_R7: assert (CNT_W'(pop_n) <= count);
    end

endmodule

// File: rtl/tagword_repacker.sv
module tagword_repacker #(
    parameter int ENTRY_W = 16,
    parameter int DEPTH   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 out_split_en,
    input  logic                 in_merge_en,
    input  logic                 host_wr_en,
    input  logic [2*ENTRY_W-1:0] host_wr_data,
    output logic                 host_out_full,
    input  logic                 host_rd_en,
    output logic [2*ENTRY_W-1:0] host_rd_data,
    output logic                 host_in_avail,
    input  logic                 eng_out_pop,
    output logic [ENTRY_W-1:0]   eng_out_entry,
    output logic                 eng_out_avail,
    input  logic                 eng_in_push,
    input  logic [ENTRY_W-1:0]   eng_in_entry,
    output logic                 eng_in_full,
    output logic                 err_overflow,
    output logic                 err_underflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic               tx_push, tx_busy, tx_ovf;
    logic [ENTRY_W-1:0] tx_data;
    logic [ENTRY_W-1:0] out_head0, out_head1;
    logic [CNT_W-1:0]   out_count;
    logic               out_full, out_empty;
    logic [1:0]         out_pop_n;

    logic [ENTRY_W-1:0] in_head0, in_head1;
    logic [CNT_W-1:0]   in_count;
    logic [1:0]         rx_pop_n;
    logic               rx_udf;

    logic ovf_q, udf_q;

    assign out_full  = (out_count == CNT_W'(DEPTH));
    assign out_empty = (out_count == '0);
    assign out_pop_n = {1'b0, eng_out_pop && !out_empty};

    repack_tx_split #(.ENTRY_W(ENTRY_W)) u_tx_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr_en),
        .wr_data   (host_wr_data),
        .split_en  (out_split_en),
        .fifo_full (out_full),
        .push      (tx_push),
        .push_data (tx_data),
        .busy      (tx_busy),
        .ovf       (tx_ovf)
    );

    repack_fifo #(.W(ENTRY_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_out_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (tx_data),
        .pop_n     (out_pop_n),
        .head0     (out_head0),
        .head1     (out_head1),
        .count     (out_count)
    );

    repack_fifo #(.W(ENTRY_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_in_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (eng_in_push),
        .push_data (eng_in_entry),
        .pop_n     (rx_pop_n),
        .head0     (in_head0),
        .head1     (in_head1),
        .count     (in_count)
    );

    repack_rx_merge #(.ENTRY_W(ENTRY_W), .CNT_W(CNT_W)) u_rx_merge (
        .rd_en    (host_rd_en),
        .merge_en (in_merge_en),
        .count    (in_count),
        .head0    (in_head0),
        .head1    (in_head1),
        .rd_data  (host_rd_data),
        .pop_n    (rx_pop_n),
        .udf      (rx_udf)
    );

    // sticky misuse flags, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_q | tx_ovf | (eng_in_push && eng_in_full);
            udf_q <= udf_q | rx_udf | (eng_out_pop && out_empty);
        end
    end

    assign host_out_full = out_full | tx_busy;
    assign host_in_avail = (in_count != '0);
    assign eng_in_full   = (in_count == CNT_W'(DEPTH));
    assign eng_out_entry = out_head0;
    assign eng_out_avail = !out_empty;
    assign err_overflow  = ovf_q;
    assign err_underflow = udf_q;

    assert_sticky_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |=> err_overflow);

    assert_sticky_udf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow);

    assert_full_write_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_out_full && host_wr_en) |=> err_overflow);

    assert_empty_pop_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_out_pop && !eng_out_avail) |=> err_underflow);

    assert_out_order_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_out_pop && out_count >= CNT_W'(2)) |=> (eng_out_entry == $past(out_head1)));

endmodule

// File: tb/tagword_repacker_tb_top.sv
module tagword_repacker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        out_split_en = 1'b0;
    logic        in_merge_en = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic        host_out_full;
    logic        host_rd_en = 1'b0;
    logic [31:0] host_rd_data;
    logic        host_in_avail;
    logic        eng_out_pop = 1'b0;
    logic [15:0] eng_out_entry;
    logic        eng_out_avail;
    logic        eng_in_push = 1'b0;
    logic [15:0] eng_in_entry = '0;
    logic        eng_in_full;
    logic        err_overflow;
    logic        err_underflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tagword_repacker #(.ENTRY_W(16), .DEPTH(DEPTH)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .out_split_en  (out_split_en),
        .in_merge_en   (in_merge_en),
        .host_wr_en    (host_wr_en),
        .host_wr_data  (host_wr_data),
        .host_out_full (host_out_full),
        .host_rd_en    (host_rd_en),
        .host_rd_data  (host_rd_data),
        .host_in_avail (host_in_avail),
        .eng_out_pop   (eng_out_pop),
        .eng_out_entry (eng_out_entry),
        .eng_out_avail (eng_out_avail),
        .eng_in_push   (eng_in_push),
        .eng_in_entry  (eng_in_entry),
        .eng_in_full   (eng_in_full),
        .err_overflow  (err_overflow),
        .err_underflow (err_underflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic do_reset();
        rst_n = 1'b0;
        host_wr_en = 1'b0;
        host_rd_en = 1'b0;
        eng_out_pop = 1'b0;
        eng_in_push = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_write(input logic [31:0] w);
        host_wr_en = 1'b1;
        host_wr_data = w;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain_expect(input string req, input logic [15:0] exp);
        chk(req, {31'd0, eng_out_avail}, 32'd1);
        chk(req, {16'd0, eng_out_entry}, {16'd0, exp});
        eng_out_pop = 1'b1;
        @(negedge clk);
        eng_out_pop = 1'b0;
    endtask

    task automatic eng_push(input logic [15:0] e);
        eng_in_push = 1'b1;
        eng_in_entry = e;
        @(negedge clk);
        eng_in_push = 1'b0;
    endtask

    task automatic read_expect(input string req, input logic [31:0] exp);
        chk(req, {31'd0, host_in_avail}, 32'd1);
        chk(req, host_rd_data, exp);
        host_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 out_full", {31'd0, host_out_full}, 32'd0);
        chk("R1 out_avail", {31'd0, eng_out_avail}, 32'd0);
        chk("R1 in_avail", {31'd0, host_in_avail}, 32'd0);
        chk("R1 in_full", {31'd0, eng_in_full}, 32'd0);
        chk("R1 errors", {30'd0, err_overflow, err_underflow}, 32'd0);
        chk("R1 rd_data", host_rd_data, 32'd0);
    endtask

    task automatic t_split_pair();
        do_reset();
        out_split_en = 1'b1;
        host_write(32'h0255_0141);
        chk("R3 hold shows full", {31'd0, host_out_full}, 32'd1);
        chk("R2 low queued first", {16'd0, eng_out_entry}, 32'h0000_0141);
        idle(1);
        chk("R3 full released", {31'd0, host_out_full}, 32'd0);
        drain_expect("R2 first entry", 16'h0141);
        drain_expect("R2 second entry", 16'h0255);
        chk("R2 drained", {31'd0, eng_out_avail}, 32'd0);
        chk("R2 no errors", {30'd0, err_overflow, err_underflow}, 32'd0);
    endtask

    task automatic t_hold_busy();
        do_reset();
        out_split_en = 1'b1;
        host_write(32'h0233_0122);
        host_write(32'h0299_0188);
        chk("R3 write during hold flags overflow", {31'd0, err_overflow}, 32'd1);
        drain_expect("R3 held low", 16'h0122);
        drain_expect("R3 held high", 16'h0233);
        chk("R3 dropped write absent", {31'd0, eng_out_avail}, 32'd0);
    endtask

    task automatic t_zero_upper();
        do_reset();
        out_split_en = 1'b1;
        host_write(32'h0000_0310);
        idle(2);
        drain_expect("R4 single entry", 16'h0310);
        chk("R4 no zero entry", {31'd0, eng_out_avail}, 32'd0);
    endtask

    task automatic t_split_off();
        do_reset();
        out_split_en = 1'b0;
        host_write(32'h0777_0205);
        chk("R5 no hold", {31'd0, host_out_full}, 32'd0);
        idle(2);
        drain_expect("R5 low only", 16'h0205);
        chk("R5 upper discarded", {31'd0, eng_out_avail}, 32'd0);
    endtask

    task automatic t_merge();
        do_reset();
        in_merge_en = 1'b1;
        eng_push(16'h01AA);
        eng_push(16'h02BB);
        eng_push(16'h03CC);
        read_expect("R6 two entries merged", 32'h02BB_01AA);
        read_expect("R7 single trailing entry", 32'h0000_03CC);
        chk("R7 one popped", {31'd0, host_in_avail}, 32'd0);
        chk("R7 no underflow", {31'd0, err_underflow}, 32'd0);
    endtask

    task automatic t_merge_off();
        do_reset();
        in_merge_en = 1'b0;
        eng_push(16'h1234);
        eng_push(16'h5678);
        read_expect("R8 first alone", 32'h0000_1234);
        read_expect("R8 second alone", 32'h0000_5678);
        chk("R8 empty after two reads", {31'd0, host_in_avail}, 32'd0);
    endtask

    task automatic t_underflow();
        do_reset();
        in_merge_en = 1'b1;
        chk("R9 empty read data", host_rd_data, 32'd0);
        host_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0;
        chk("R9 read underflow", {31'd0, err_underflow}, 32'd1);
        chk("R9 queue untouched", {31'd0, host_in_avail}, 32'd0);
        eng_push(16'h0042);
        read_expect("R9 queue still consistent", 32'h0000_0042);
        do_reset();
        eng_out_pop = 1'b1;
        @(negedge clk);
        eng_out_pop = 1'b0;
        chk("R9 pop underflow", {31'd0, err_underflow}, 32'd1);
        chk("R9 out still empty", {31'd0, eng_out_avail}, 32'd0);
        chk("R9 no overflow", {31'd0, err_overflow}, 32'd0);
    endtask

    task automatic t_out_overflow();
        do_reset();
        out_split_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            chk("R11 not full yet", {31'd0, host_out_full}, 32'd0);
            host_write(32'h0000_0100 + 32'(i));
        end
        chk("R11 out full", {31'd0, host_out_full}, 32'd1);
        host_write(32'h0000_01FF);
        chk("R10 out overflow", {31'd0, err_overflow}, 32'd1);
        idle(3);
        chk("R10 overflow sticky", {31'd0, err_overflow}, 32'd1);
        for (int i = 0; i < DEPTH; i++) begin
            drain_expect("R12 out order", 16'h0100 + 16'(i));
        end
        chk("R10 dropped entry absent", {31'd0, eng_out_avail}, 32'd0);
        chk("R10 overflow still sticky", {31'd0, err_overflow}, 32'd1);
    endtask

    task automatic t_in_overflow();
        do_reset();
        in_merge_en = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            eng_push(16'h0A10 + 16'(i));
        end
        chk("R11 in full", {31'd0, eng_in_full}, 32'd1);
        eng_push(16'h0AEE);
        chk("R10 in overflow", {31'd0, err_overflow}, 32'd1);
        for (int k = 0; k < DEPTH / 2; k++) begin
            read_expect("R12 in order merged",
                        {16'h0A11 + 16'(2 * k), 16'h0A10 + 16'(2 * k)});
        end
        chk("R10 in dropped entry absent", {31'd0, host_in_avail}, 32'd0);
    endtask

    task automatic t_wrap();
        do_reset();
        out_split_en = 1'b1;
        for (int r = 0; r < 3; r++) begin
            for (int j = 0; j < 3; j++) begin
                logic [15:0] lo;
                lo = 16'h0120 + 16'(2 * j + 16 * r);
                host_write({lo + 16'd1, lo});
                idle(1);
            end
            for (int j = 0; j < 6; j++) begin
                drain_expect("R12 wrap order", 16'h0120 + 16'(j + 16 * r));
            end
        end
        chk("R12 wrap drained", {31'd0, eng_out_avail}, 32'd0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_split_pair();
        t_hold_busy();
        t_zero_upper();
        t_split_off();
        t_merge();
        t_merge_off();
        t_underflow();
        t_out_overflow();
        t_in_overflow();
        t_wrap();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule